// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is a small programmable logic element. It holds four truth tables of sixteen one-bit entries each. A selected variable vector addresses those tables, and a width setting decides how many of the six variables take part in the function. With four variables, one table is read directly. With five or six variables, the extra variables act as multiplexer selects that choose between tables, each of which holds a cofactor of the wider function. This is the Shannon expansion applied in hardware.

The truth-table contents arrive over a one-bit serial port. They shift in one bit per clock while the load enable is high, and a complete load takes 64 clocks. A final output multiplexer chooses between two sources. One is the combinational result. The other is a copy of that result captured in a D flip-flop on each rising edge, and this flip-flop has a synchronous clear. The output has no defined meaning while a load is in progress.

Top module: `lutcell_top`

## Requirements
- R1: While `cfg_en` is high, the cell takes one bit from `cfg_din` on every rising clock edge. After exactly 64 such edges, the first bit sent is entry 15 of table 3 and the last bit sent is entry 0 of table 0. The order runs through table 3, then table 2, then table 1, then table 0, and within each table it runs from entry 15 down to entry 0.
- R2: While `cfg_en` is low, the stored tables do not change, whatever value `cfg_din` carries.
- R3: With `mode` = 0, the result is entry `vars[3:0]` of table 0, and `vars[5:4]` has no effect.
- R4: With `mode` = 1, the result is entry `vars[3:0]` of table 0 when `vars[4]` is 0, and of table 1 when `vars[4]` is 1. `vars[5]` has no effect.
- R5: With `mode` = 2, the result is entry `vars[3:0]` of table number {`vars[5]`,`vars[4]`}. `vars[5]` picks the pair (tables 0 and 1) or the pair (tables 2 and 3), and `vars[4]` picks the table within that pair.
- R6: `mode` = 3 behaves exactly like `mode` = 2.
- R7: With `reg_sel` low, `f_out` follows the combinational result in the same cycle that the inputs change.
- R8: With `reg_sel` high, `f_out` shows the flip-flop. The flip-flop loads the combinational result on each rising edge, so a change of inputs appears only after the next rising edge.
- R9: When `rst` is high at a rising edge, the flip-flop becomes 0 at that edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous, active-high clear of the output flip-flop |
| cfg_en | input | 1 | Shift enable for the truth-table load |
| cfg_din | input | 1 | Serial truth-table data |
| mode | input | 2 | Function width: 0 = four variables, 1 = five, 2 or 3 = six |
| reg_sel | input | 1 | 1 selects the registered output, 0 the combinational one |
| vars | input | 6 | Function variables; [3:0] address the tables, [5:4] select among them |
| f_out | output | 1 | Cell output |

## Verification
The hardest thing to reach from the ports is every single table entry in every width setting. The port has no random access, so each new truth-table pattern costs a full 64-clock serial load. Each load is then followed by a sweep of all 64 variable combinations in every mode. Random tables from a seeded generator are mixed with directed loads:
- a lone bit at each end of the chain, which proves the load order;
- one-minterm and fifteen-minterm tables;
- the three-variable majority function and the three-variable parity function, each written as two cofactors and selected by one variable.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

   typedef enum logic [1:0] {
      WIDTH_BASE  = 2'd0,
      WIDTH_PLUS1 = 2'd1,
      WIDTH_FULL  = 2'd2,
      WIDTH_FULLB = 2'd3
   } width_mode_e;

   // Number of select variables that take part for a given width setting.
   function automatic int unsigned sel_bits_used(input width_mode_e m,
                                                 input int unsigned max_sel);
      int unsigned n;
      case (m)
         WIDTH_BASE:  n = 0;
         WIDTH_PLUS1: n = 1;
         default:     n = max_sel;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/lutcell_cfg_chain.sv
module lutcell_cfg_chain #(
   parameter int unsigned DEPTH = 64
) (
   input  logic             clk,
   input  logic             shift_en,
   input  logic             din,
   output logic [DEPTH-1:0] bits_q
);

   // Newest bit enters at position 0; the first bit sent ends at DEPTH-1.
   always_ff @(posedge clk) begin
      if (shift_en) begin
         bits_q <= {bits_q[DEPTH-2:0], din};
      end
   end

endmodule

// File: rtl/lutcell_lut.sv
module lutcell_lut #(
   parameter int unsigned K = 4,
   localparam int unsigned ENTRIES = 1 << K
) (
   input  logic [ENTRIES-1:0] table_bits,
   input  logic [K-1:0]       addr,
   output logic               y
);

   assign y = table_bits[addr];

endmodule

// File: rtl/lutcell_expand_mux.sv
module lutcell_expand_mux
   import lutcell_pkg::*;
#(
   parameter int unsigned NUM_LUT = 4,
   localparam int unsigned SEL_W = $clog2(NUM_LUT)
) (
   input  logic [NUM_LUT-1:0] cof,
   input  width_mode_e        mode,
   input  logic [SEL_W-1:0]   sel_vars,
   output logic               y
);

   int unsigned      n_used;
   logic [SEL_W-1:0] idx;

   // Select variables beyond the active width are forced to zero, so the
   // narrower modes always draw on the lowest-numbered tables.
   always_comb begin
      n_used = sel_bits_used(mode, SEL_W);
      idx    = '0;
      for (int i = 0; i < SEL_W; i++) begin
         if (i < n_used) idx[i] = sel_vars[i];
      end
      y = cof[idx];
   end

endmodule

// File: rtl/lutcell_top.sv
module lutcell_top
   import lutcell_pkg::*;
#(
   parameter int unsigned LUT_K   = 4,
   parameter int unsigned NUM_LUT = 4,
   localparam int unsigned SEL_W   = $clog2(NUM_LUT),
   localparam int unsigned NVARS   = LUT_K + SEL_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_en,
   input  logic             cfg_din,
   input  logic [1:0]       mode,
   input  logic             reg_sel,
   input  logic [NVARS-1:0] vars,
   output logic             f_out
);

   localparam int unsigned LUT_BITS = 1 << LUT_K;
   localparam int unsigned CFG_BITS = LUT_BITS * NUM_LUT;

   // Elaboration-time parameter checks
   if (LUT_K < 2 || LUT_K > 6) begin : g_bad_k
      $error("lutcell_top: LUT_K must lie in 2..6");
   end
   if (NUM_LUT < 2 || NUM_LUT != (1 << SEL_W)) begin : g_bad_n
      $error("lutcell_top: NUM_LUT must be a power of two, at least 2");
   end

   logic [CFG_BITS-1:0] cfg_bits;
   logic [NUM_LUT-1:0]  lut_y;
   logic                comb_y;
   logic                ff_q;

   lutcell_cfg_chain #(.DEPTH(CFG_BITS)) u_chain (
      .clk      (clk),
      .shift_en (cfg_en),
      .din      (cfg_din),
      .bits_q   (cfg_bits)
   );

   for (genvar g = 0; g < NUM_LUT; g++) begin : g_lut
      lutcell_lut #(.K(LUT_K)) u_lut (
         .table_bits (cfg_bits[g*LUT_BITS +: LUT_BITS]),
         .addr       (vars[LUT_K-1:0]),
         .y          (lut_y[g])
      );
   end

   lutcell_expand_mux #(.NUM_LUT(NUM_LUT)) u_mux (
      .cof      (lut_y),
      .mode     (width_mode_e'(mode)),
      .sel_vars (vars[NVARS-1:LUT_K]),
      .y        (comb_y)
   );

   always_ff @(posedge clk) begin
      if (rst) ff_q <= 1'b0;
      else     ff_q <= comb_y;
   end

   assign f_out = reg_sel ? ff_q : comb_y;

endmodule

// File: rtl/lutcell_chk.sv
module lutcell_chk #(
   parameter int unsigned LUT_K   = 4,
   parameter int unsigned NUM_LUT = 4,
   localparam int unsigned SEL_W    = $clog2(NUM_LUT),
   localparam int unsigned NVARS    = LUT_K + SEL_W,
   localparam int unsigned CFG_BITS = (1 << LUT_K) * NUM_LUT
) (
   input logic                clk,
   input logic                rst,
   input logic                cfg_en,
   input logic                cfg_din,
   input logic [1:0]          mode,
   input logic                reg_sel,
   input logic [NVARS-1:0]    vars,
   input logic [CFG_BITS-1:0] cfg_bits,
   input logic                comb_y,
   input logic                f_out
);

   p_shift_r1: assert property (@(posedge clk) disable iff (rst)
      cfg_en |=> cfg_bits == {$past(cfg_bits[CFG_BITS-2:0]), $past(cfg_din)});

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !cfg_en |=> $stable(cfg_bits));

   p_base_r3: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd0) |-> comb_y == cfg_bits[vars[LUT_K-1:0]]);

   p_plus1_r4: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd1) |-> comb_y == cfg_bits[{vars[LUT_K], vars[LUT_K-1:0]}]);

   // R5 and R6: both full-width codes address the whole chain with all variables
   p_full_r5: assert property (@(posedge clk) disable iff (rst)
      mode[1] |-> comb_y == cfg_bits[vars]);

   p_regout_r8: assert property (@(posedge clk) disable iff (rst)
      (!rst ##1 reg_sel) |-> f_out == $past(comb_y));

endmodule

bind lutcell_top lutcell_chk #(.LUT_K(LUT_K), .NUM_LUT(NUM_LUT)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cfg_en   (cfg_en),
   .cfg_din  (cfg_din),
   .mode     (mode),
   .reg_sel  (reg_sel),
   .vars     (vars),
   .cfg_bits (cfg_bits),
   .comb_y   (comb_y),
   .f_out    (f_out)
);

// File: tb/tb_lutcell_top.sv
module tb_lutcell_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_en = 1'b0;
   logic       cfg_din = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       reg_sel = 1'b1;
   logic [5:0] vars = 6'd0;
   logic       f_out;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   lutcell_top dut (
      .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .mode(mode), .reg_sel(reg_sel), .vars(vars), .f_out(f_out)
   );

   function automatic logic exp_f(input logic [63:0] tt, input logic [1:0] m,
                                  input logic [5:0] v);
      logic [1:0] t;
      case (m)
         2'd0:    t = 2'd0;
         2'd1:    t = {1'b0, v[4]};
         default: t = v[5:4];
      endcase
      return tt[{t, v[3:0]}];
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic load(input logic [63:0] tt);
      @(negedge clk);
      cfg_en = 1'b1;
      for (int i = 63; i >= 0; i--) begin
         cfg_din = tt[i];
         @(negedge clk);
      end
      cfg_en = 1'b0;
   endtask

   task automatic sweep(input logic [63:0] tt, input logic [1:0] m, input string req);
      reg_sel = 1'b0;
      mode = m;
      for (int v = 0; v < 64; v++) begin
         @(negedge clk);
         vars = 6'(v);
         #1 chk(req, f_out, exp_f(tt, m, 6'(v)));
      end
   endtask

   initial begin
      logic [63:0] tt;
      logic        prev;
      void'($urandom(32'd2024));

      // reset state, R9
      repeat (3) @(negedge clk);
      #1 chk("R9 reset state", f_out, 1'b0);
      rst = 1'b0;

      // R1 ordering: a lone bit at each end of the chain
      tt = 64'h1 << 63;
      load(tt);
      sweep(tt, 2'd2, "R1 first bit -> table3 entry15");
      tt = 64'h1;
      load(tt);
      sweep(tt, 2'd2, "R1 last bit -> table0 entry0");

      // R3: one minterm, fifteen minterms, upper variables ignored
      tt = {48'hFFFF_FFFF_FFFF, 16'h4000};
      load(tt);
      sweep(tt, 2'd0, "R3 single minterm");
      tt = {48'h0, 16'hBFFF};
      load(tt);
      sweep(tt, 2'd0, "R3 fifteen minterms");

      // R4: majority of x1,x2,x3 via expansion on x1 = vars[4]
      tt = '0;
      for (int a = 0; a < 16; a++) begin
         tt[a]      = a[1] & a[0];
         tt[16 + a] = a[1] | a[0];
      end
      tt[63:32] = $urandom();
      load(tt);
      reg_sel = 1'b0;
      mode = 2'd1;
      for (int v = 0; v < 64; v++) begin
         @(negedge clk);
         vars = 6'(v);
         #1 chk("R4 majority", f_out,
                (vars[4] & vars[1]) | (vars[4] & vars[0]) | (vars[1] & vars[0]));
      end

      // R4: parity of x1,x2,x3 via expansion on x1 = vars[4]
      tt = '0;
      for (int a = 0; a < 16; a++) begin
         tt[a]      = a[1] ^ a[0];
         tt[16 + a] = ~(a[1] ^ a[0]);
      end
      tt[63:32] = $urandom();
      load(tt);
      for (int v = 0; v < 64; v++) begin
         @(negedge clk);
         vars = 6'(v);
         #1 chk("R4 parity", f_out, vars[4] ^ vars[1] ^ vars[0]);
      end

      // random tables in every width, R3 R4 R5 R6
      for (int k = 0; k < 6; k++) begin
         tt = {$urandom(), $urandom()};
         load(tt);
         sweep(tt, 2'd0, "R3 random");
         sweep(tt, 2'd1, "R4 random");
         sweep(tt, 2'd2, "R5 random");
         sweep(tt, 2'd3, "R6 random");
      end

      // R2: toggle cfg_din with enable low; tables must stay put
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         cfg_din = $urandom();
      end
      sweep(tt, 2'd2, "R2 hold");

      // R7 already exercised by sweeps; R8 registered path
      mode = 2'd2;
      @(negedge clk);
      reg_sel = 1'b1;
      vars = 6'd0;
      @(posedge clk);
      prev = exp_f(tt, 2'd2, 6'd0);
      for (int i = 0; i < 40; i++) begin
         logic [5:0] v;
         v = 6'($urandom());
         @(negedge clk);
         vars = v;
         #1 chk("R8 holds until edge", f_out, prev);
         @(posedge clk);
         #1 chk("R8 after edge", f_out, exp_f(tt, 2'd2, v));
         prev = exp_f(tt, 2'd2, v);
      end

      // R9: synchronous clear while the result is 1
      tt = 64'hFFFF_FFFF_FFFF_FFFF;
      load(tt);
      @(posedge clk);
      #1 chk("R8 all-ones", f_out, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      #1 chk("R9 not before edge", f_out, 1'b1);
      @(posedge clk);
      #1 chk("R9 cleared at edge", f_out, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      reg_sel = 1'b0;
      #1 chk("R7 combinational view", f_out, 1'b1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule